// File: doc/BRIEF.md
# CAN Receive Frame Queue with Coalesced Interrupt

This block sits between the receive side of a CAN controller and the host. Completed frames arrive on a one-cycle ingest strobe and are stored in a queue whose pointers are kept entirely in hardware. The host never handles an index. It reads the oldest frame through a fixed window address. It then retires any number of frames by writing that number to an acknowledge register, and the next oldest frame appears in the window.

To keep the interrupt rate low, the block coalesces receive events in two ways. A level flag sets once the number of stored frames rises above a programmable threshold. A timeout flag sets when frames are waiting and the host has neither read the window nor acknowledged anything for a programmable number of 100 µs ticks. A third flag reports frames lost because the queue was full. Each flag has its own enable, and the interrupt output is the OR of the enabled flags.

Top module: `can_rx_frame_queue`

Register word addresses on `reg_addr`: 0 frame window (read), 1 status (read, write-1-to-clear), 2 level threshold, 3 acknowledge (write), 4 interrupt enables, 5 timeout in ticks.

## Requirements
- R1: After reset the status register reads 0 (no frames, no flags) and `irq` is low. The threshold resets to 0, the enables to 0 and the timeout to 65535.
- R2: The frame window (address 0) always shows the oldest stored frame, in arrival order, across pointer wrap. Writing N to the acknowledge register (address 3, count in bits 7:0) removes the N oldest frames.
- R3: The level flag (status bit 16) sets when the stored count is strictly greater than the threshold in bits 15:0 of address 2. A threshold of 0 fires on one frame.
- R4: Status bits 7:0 give the number of stored frames. Writing 1 to bit 16, 17 or 23 of the status register clears that flag; a set condition in the same cycle wins.
- R5: The timeout flag (status bit 23) sets when the queue is non-empty and the elapsed time since the last restart reaches the value in bits 15:0 of address 5. Time is counted in ticks of CLK_HZ/10000 clock cycles, i.e. 100 µs.
- R6: A read of the frame window, a write to the acknowledge register, or an empty queue restarts the timeout measurement.
- R7: A frame that arrives while DEPTH (255) frames are stored is dropped and sets the overrun flag (status bit 17). The stored frames and the count are left unchanged.
- R8: An acknowledge count larger than the stored count empties the queue and advances the read position only by the stored count.
- R9: `irq` is high exactly when an enabled flag is set. The enables at address 4 are: bit 0 for the level flag, bit 1 for overrun, bit 7 for timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: a completed frame is present |
| in_frame | input | FRAME_W | Frame word to store |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks window reads) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The queue is driven with short bursts popped one by one, and with a full fill of 255 frames followed by one extra frame. This separates correct ordering from pointer wrap errors, and shows whether the dropped frame corrupts stored data. An over-large acknowledge followed by a fresh frame shows whether the read position moves by the clamped or the raw count. The coalescing flags are probed just below and just above their thresholds: the count-over-level edge, including level 0, and the tick count with and without an intervening window read. These probes separate strict from inclusive comparison and show whether host activity restarts the timer.

// File: rtl/can_rxq_pkg.sv
// Shared constants and types for the receive frame queue.
// Assumes a 32-bit register bus with word addresses on a 3-bit field.
package can_rxq_pkg;
    localparam logic [2:0] ADDR_WIN  = 3'd0;
    localparam logic [2:0] ADDR_STAT = 3'd1;
    localparam logic [2:0] ADDR_LVL  = 3'd2;
    localparam logic [2:0] ADDR_ACK  = 3'd3;
    localparam logic [2:0] ADDR_IEN  = 3'd4;
    localparam logic [2:0] ADDR_TOUT = 3'd5;

    localparam int BIT_RXF = 16;
    localparam int BIT_OVF = 17;
    localparam int BIT_TOF = 23;
    localparam int BIT_RXE = 0;
    localparam int BIT_OVE = 1;
    localparam int BIT_TOE = 7;

    typedef struct packed {
        logic tout;
        logic ovr;
        logic lvl;
    } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
// Circular frame store with hardware read/write pointers.
// Accepts one frame per cycle and retires a clamped count of frames per cycle.
// Assumes DEPTH >= 2; pointers and count share one width.
module rxq_store #(
    parameter int DEPTH   = 255,
    parameter int FRAME_W = 32,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [FRAME_W-1:0] data_i,
    input  logic [CNT_W-1:0]   pop_n_i,
    output logic [FRAME_W-1:0] head_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               drop_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W:0]   DEPTH_X = (CNT_W + 1)'(DEPTH);

    logic [FRAME_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]   wr_ptr, rd_ptr, count_q;
    logic [CNT_W-1:0]   pop_eff, rd_next, wr_next;
    logic [CNT_W:0]     rd_sum, wr_sum;
    logic               accept;

    // Clamp the retire count and compute wrapped next pointers.
    always_comb begin
        pop_eff = (pop_n_i > count_q) ? count_q : pop_n_i;
        accept  = push_i && (count_q != DEPTH_C);
        drop_o  = push_i && (count_q == DEPTH_C);
        rd_sum  = {1'b0, rd_ptr} + {1'b0, pop_eff};
        if (rd_sum >= DEPTH_X) rd_sum = rd_sum - DEPTH_X;
        rd_next = rd_sum[CNT_W-1:0];
        wr_sum  = {1'b0, wr_ptr} + (CNT_W + 1)'(1);
        if (wr_sum >= DEPTH_X) wr_sum = wr_sum - DEPTH_X;
        wr_next = wr_sum[CNT_W-1:0];
    end

    // Frame storage, written only when a slot is free.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (accept) wr_ptr <= wr_next;
            rd_ptr  <= rd_next;
            count_q <= count_q + CNT_W'(accept) - pop_eff;
        end
    end

    assign head_o  = mem[rd_ptr];
    assign count_o = count_q;

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= DEPTH_C);
    p_full_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && count_q == DEPTH_C && pop_n_i == '0) |=> $stable(count_q));
    p_ack_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && pop_n_i >= count_q) |=> (count_q == '0));
endmodule

// File: rtl/rxq_tick.sv
// Prescaler that emits one pulse per 100 us derived from CLK_HZ.
// A clear restarts the phase so that tick timing is measured from the clear.
module rxq_tick #(
    parameter int CLK_HZ  = 250_000_000,
    parameter int TICK_HZ = 10_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DIV   = (CLK_HZ / TICK_HZ) < 1 ? 1 : (CLK_HZ / TICK_HZ);
    localparam int DIV_W = $clog2(DIV + 1);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] presc_q;

    // Count clock cycles within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)      presc_q <= '0;
        else if (presc_q == LAST) presc_q <= '0;
        else                      presc_q <= presc_q + 1'b1;
    end

    assign tick_o = !clr_i && (presc_q == LAST);
endmodule

// File: rtl/rxq_idle_timer.sv
// Counts ticks since the last restart, saturating, and reports when the
// programmed limit is reached. Assumes the caller restarts it on host activity.
module rxq_idle_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    logic [TW-1:0] ticks_q;

    // Saturating tick accumulator with restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                 ticks_q <= '0;
        else if (tick_i && ticks_q != '1)    ticks_q <= ticks_q + 1'b1;
    end

    assign expired_o = !clr_i && (ticks_q >= limit_i);
endmodule

// File: rtl/can_rx_frame_queue.sv
// Receive frame queue with register access and coalesced interrupt.
// Decodes the host registers, holds the three sticky flags and combines them
// with their enables. Assumes FRAME_W <= 32 and DEPTH < 65536.
module can_rx_frame_queue
    import can_rxq_pkg::*;
#(
    parameter int DEPTH   = 255,
    parameter int FRAME_W = 32,
    parameter int CLK_HZ  = 250_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [FRAME_W-1:0] head;
    logic [CNT_W-1:0]   count, pop_n;
    logic               drop, touch, restart, tick, expired, nonempty;
    logic [15:0]        level_q, tout_q;
    rxq_flags_t         flags_q, ien_q, clr_set;
    logic               unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:24], reg_wdata[22:18]};

    // Decode host strobes into retire count, activity and flag clears.
    always_comb begin
        pop_n   = (reg_wr && reg_addr == ADDR_ACK) ? reg_wdata[CNT_W-1:0] : '0;
        touch   = (reg_rd && reg_addr == ADDR_WIN) || (reg_wr && reg_addr == ADDR_ACK);
        nonempty = (count != '0);
        restart = touch || !nonempty;
        clr_set = '0;
        if (reg_wr && reg_addr == ADDR_STAT)
            clr_set = '{tout: reg_wdata[BIT_TOF], ovr: reg_wdata[BIT_OVF], lvl: reg_wdata[BIT_RXF]};
    end

    rxq_store #(.DEPTH(DEPTH), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push_i(in_valid), .data_i(in_frame),
        .pop_n_i(pop_n), .head_o(head), .count_o(count), .drop_o(drop)
    );

    rxq_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(10_000)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr_i(restart), .tick_o(tick)
    );

    rxq_idle_timer #(.TW(16)) u_idle (
        .clk(clk), .rst_n(rst_n), .clr_i(restart), .tick_i(tick),
        .limit_i(tout_q), .expired_o(expired)
    );

    // Configuration registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            tout_q  <= '1;
            ien_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_LVL)  level_q <= reg_wdata[15:0];
            if (reg_addr == ADDR_TOUT) tout_q  <= reg_wdata[15:0];
            if (reg_addr == ADDR_IEN)
                ien_q <= '{tout: reg_wdata[BIT_TOE], ovr: reg_wdata[BIT_OVE], lvl: reg_wdata[BIT_RXE]};
        end
    end

    // Sticky flags: set by their condition, cleared by write-one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q.lvl  <= (flags_q.lvl  && !clr_set.lvl)  || (16'(count) > level_q);
            flags_q.ovr  <= (flags_q.ovr  && !clr_set.ovr)  || drop;
            flags_q.tout <= (flags_q.tout && !clr_set.tout) || (expired && nonempty);
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_WIN:  reg_rdata = 32'(head);
            ADDR_STAT: begin
                reg_rdata[CNT_W-1:0] = count;
                reg_rdata[BIT_RXF]   = flags_q.lvl;
                reg_rdata[BIT_OVF]   = flags_q.ovr;
                reg_rdata[BIT_TOF]   = flags_q.tout;
            end
            ADDR_LVL:  reg_rdata[15:0] = level_q;
            ADDR_IEN: begin
                reg_rdata[BIT_RXE] = ien_q.lvl;
                reg_rdata[BIT_OVE] = ien_q.ovr;
                reg_rdata[BIT_TOE] = ien_q.tout;
            end
            ADDR_TOUT: reg_rdata[15:0] = tout_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(flags_q & ien_q);

    p_lvl_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.lvl) |-> $past(16'(count) > level_q));
    p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.ovr) |-> $past(in_valid));
    p_tout_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.tout) |-> $past(count != '0));
    p_irq_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q != '0));
endmodule

// File: tb/tb_can_rx_frame_queue.sv
// Scoreboard bench: the push driver predicts stored frames into a queue and
// the pop monitor compares each window read against the oldest prediction.
module tb_can_rx_frame_queue;
    localparam int DEPTH = 255;
    localparam int TICKC = 10;   // CLK_HZ 100_000 -> 10 cycles per tick

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_frame = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];

    always #2 clk = ~clk;

    can_rx_frame_queue #(.DEPTH(DEPTH), .FRAME_W(32), .CLK_HZ(100_000)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: push one frame and predict whether it is kept.
    task automatic push_frame(input logic [31:0] d);
        in_valid = 1'b1;
        in_frame = d;
        @(negedge clk);
        in_valid = 1'b0;
        if (exp_q.size() < DEPTH) exp_q.push_back(d);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Monitor: read the window, compare with the oldest prediction, retire it.
    task automatic pop_check(input string tag);
        logic [31:0] v, e;
        reg_read(3'd0, v);
        e = exp_q.pop_front();
        check(tag, v, e);
        reg_write(3'd3, 32'd1);
    endtask

    task automatic drop_expected(input int n);
        repeat (n) void'(exp_q.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        reg_read(3'd1, v); check("R1 status after reset", v, 32'h0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        reg_read(3'd5, v); check("R1 timeout reset value", v, 32'h0000_FFFF);
        reg_write(3'd2, 32'd300);

        // R2, R4: ordering and count field
        push_frame(32'hA000_0001); push_frame(32'hA000_0002); push_frame(32'hA000_0003);
        reg_read(3'd1, v); check("R4 count field three frames", v, 32'd3);
        pop_check("R2 window order 1"); pop_check("R2 window order 2"); pop_check("R2 window order 3");

        // R3: strict level compare, R9 irq, R4 write-one-to-clear
        reg_write(3'd2, 32'd2);
        push_frame(32'hB1); push_frame(32'hB2); idle(1);
        reg_read(3'd1, v); check("R3 no flag at count equal to level", v[16], 1'b0);
        push_frame(32'hB3); idle(1);
        reg_read(3'd1, v); check("R3 flag when count above level", v[16], 1'b1);
        check("R9 irq low while disabled", {31'd0, irq}, 32'd0);
        reg_write(3'd4, 32'h1); idle(1);
        check("R9 irq from enabled level flag", {31'd0, irq}, 32'd1);
        pop_check("R2 pop B1"); pop_check("R2 pop B2"); pop_check("R2 pop B3");
        reg_write(3'd1, 32'h0001_0000); idle(1);
        reg_read(3'd1, v); check("R4 level flag cleared by write one", v, 32'h0);
        check("R9 irq low after clear", {31'd0, irq}, 32'd0);
        reg_write(3'd4, 32'h0);

        // R3: level 0 fires on a single frame
        reg_write(3'd2, 32'd0);
        push_frame(32'hC1); idle(1);
        reg_read(3'd1, v); check("R3 level zero fires on one frame", v[16], 1'b1);
        pop_check("R2 pop C1");
        reg_write(3'd2, 32'd300);
        reg_write(3'd1, 32'h0001_0000);

        // R8: acknowledge clamp
        push_frame(32'hD1); push_frame(32'hD2);
        reg_write(3'd3, 32'd10); drop_expected(2);
        reg_read(3'd1, v); check("R8 clamped ack empties queue", v, 32'h0);
        push_frame(32'hD3);
        pop_check("R8 read position after clamped ack");

        // R5: timeout after 3 ticks of inactivity
        reg_write(3'd5, 32'd3);
        push_frame(32'hE1);
        idle(3 * TICKC - 5);
        reg_read(3'd1, v); check("R5 no timeout before limit", v[23], 1'b0);
        idle(14);
        reg_read(3'd1, v); check("R5 timeout flag after limit", v[23], 1'b1);
        reg_write(3'd4, 32'h80); idle(1);
        check("R9 irq from enabled timeout flag", {31'd0, irq}, 32'd1);
        reg_write(3'd4, 32'h0);
        pop_check("R2 pop E1");
        reg_write(3'd1, 32'h0080_0000);

        // R6: window read restarts the timeout
        push_frame(32'hE2);
        idle(20);
        reg_read(3'd0, v);
        idle(20);
        reg_read(3'd1, v); check("R6 window read restarted timeout", v[23], 1'b0);
        idle(14);
        reg_read(3'd1, v); check("R6 timeout after restart window", v[23], 1'b1);
        pop_check("R2 pop E2");
        reg_write(3'd1, 32'h0080_0000);
        reg_write(3'd5, 32'hFFFF);

        // R7: overrun at full, contents kept, pointer wrap
        for (int i = 0; i < DEPTH; i++) push_frame(32'h5000_0000 + i);
        reg_read(3'd1, v); check("R7 full count and no overrun yet", v, 32'd255);
        push_frame(32'hDEAD_BEEF);
        reg_read(3'd1, v); check("R7 dropped frame sets overrun, count kept", v, 32'h0002_00FF);
        reg_write(3'd4, 32'h2); idle(1);
        check("R9 irq from enabled overrun flag", {31'd0, irq}, 32'd1);
        reg_write(3'd4, 32'h0);
        for (int i = 0; i < DEPTH; i++) pop_check("R7 contents after overrun");
        reg_write(3'd1, 32'h0002_0000);
        reg_read(3'd1, v); check("R7 queue empty and overrun cleared", v, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule